// File: doc/BRIEF.md
# Receive Descriptor Ring Filler

This block takes a received frame as a byte stream and spreads it over the empty receive buffer descriptors of a circular ring in memory. Each descriptor is 8 bytes long, read and written as one 64-bit word: flags in bits 63:48, length in bits 47:32 and buffer address in bits 31:0. One descriptor takes at most the programmed maximum buffer length. The byte stream written for a frame is an optional zero-filled control block, then the frame data, then four zero bytes that hold the place of the CRC. One frame may cover several descriptors.

The frame length comes on `in_len` together with the first byte. At that first byte the block decides whether to accept the frame or drop it. For an accepted frame it fetches descriptors, writes the buffer bytes, and writes each descriptor back with updated flags and length. It can also raise a receive interrupt.

When the walk runs out of usable descriptors in the middle of a frame, the block sets a queue-halt status bit. It keeps the unwritten remainder by stalling the input. Once software clears that bit, the walk resumes from the saved pointer.

Top module: `rx_ring_filler`

## Requirements
- R1: Only a descriptor whose empty flag (bit 15) is set gets filled. Its write-back has the empty flag cleared and a length equal to the number of bytes written into its buffer.
- R2: A descriptor never holds more than `max_buf_len` bytes. A frame continues in the next descriptor: the ring base if the wrap flag (bit 13) was set, otherwise the current address plus 8.
- R3: After the frame data, four zero bytes follow in the same stream, and they also spill into the next descriptor when the current buffer is full.
- R4: When `parse_depth` is nonzero, 8 + `cb_align` zero bytes are written ahead of the data in the first buffer of the frame. When it is zero, nothing is written ahead of the data.
- R5: The first descriptor of a frame gets the first flag (bit 14). The last descriptor has flag bits 10:0 cleared and the last flag (bit 11) set. Other flags keep their value.
- R6: On the last descriptor, bit 5 is set when `in_len`+4 >= `max_frame_len`, and bit 3 is set when `in_len`+4 < 64.
- R7: A frame is dropped when `rx_enable` is low, when `graceful_stop` is high, or when `reject_short` is high and `in_len` < 60. A dropped frame's bytes are all consumed, and nothing is written to memory.
- R8: A descriptor written back with its interrupt flag (bit 12) set does one of two things. If it is last, it sets status bit 7-RING and pulses `rx_irq` when `irq_frame_en` is high. Otherwise it pulses `rx_irq` when `irq_buf_en` is high.
- R9: The walk stops mid-frame in two cases. At a non-empty descriptor, the pointer stays on that descriptor. When the next descriptor would be the one where the walk started, the pointer points there. In both cases status bit 23-RING is set.
- R10: While status bit 23-RING is set, `in_ready` stays low. Clearing the bit through `stat_clr` (write one to clear) resumes the frame from the pointer, without a second first flag.
- R11: After a frame completes, `ring_ptr` addresses the descriptor after the last one filled.
- R12: After reset, `in_ready`, `stat` and all memory strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | 32 | Ring start address (low 3 bits ignored) |
| ptr_wr | input | 1 | Load the descriptor pointer (taken while idle or halted) |
| ptr_wdata | input | 32 | Pointer value to load |
| ring_ptr | output | 32 | Current descriptor pointer |
| max_buf_len | input | 16 | Bytes allowed per buffer (must exceed 39) |
| max_frame_len | input | 16 | Length-violation threshold |
| rx_enable | input | 1 | Receive enable |
| graceful_stop | input | 1 | Stop request; new frames are dropped |
| reject_short | input | 1 | Drop frames with fewer than 60 bytes |
| parse_depth | input | 2 | Nonzero enables the control block |
| cb_align | input | 5 | Extra control-block bytes |
| irq_frame_en | input | 1 | Interrupt enable for frame events |
| irq_buf_en | input | 1 | Interrupt enable for buffer events |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte taken |
| in_data | input | 8 | Frame byte |
| in_len | input | 16 | Frame length, held during the frame (at least 1) |
| desc_rd | output | 1 | Descriptor read; data one cycle later |
| desc_wr | output | 1 | Descriptor write-back |
| desc_addr | output | 32 | Descriptor address |
| desc_rdata | input | 64 | Descriptor read data |
| desc_wdata | output | 64 | Descriptor write data |
| data_wr | output | 1 | Buffer byte write |
| data_addr | output | 32 | Buffer byte address |
| data_byte | output | 8 | Buffer byte value |
| stat | output | 32 | Sticky status bits |
| stat_clr | input | 32 | Write-one-to-clear for `stat` |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench builds the block with RING=2. This places the halt flag at bit 21 and the frame flag at bit 5, so a design that ignores the ring number is caught. It uses an 8-descriptor ring with wrap on the last entry, and buffer lengths from 48 to 128. With these values a random frame can span the whole ring and exercise the wrap. Lap and non-empty halts, padding that crosses a buffer boundary and the 59/60-byte drop boundary are all reachable with short runs.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int ADDR_W  = 32;
    localparam int LEN_W   = 16;
    localparam int CB_W    = 6;
    localparam int REM_W   = LEN_W + 1;
    localparam int STRIDE  = 8;
    localparam int PAD_N   = 4;
    localparam int CB_BASE = 8;
    localparam int SHORT_DROP = 60;
    localparam int SHORT_MARK = 64;

    localparam int F_EMPTY = 15;
    localparam int F_FIRST = 14;
    localparam int F_WRAP  = 13;
    localparam int F_INT   = 12;
    localparam int F_LAST  = 11;
    localparam int F_LG    = 5;
    localparam int F_SH    = 3;

    typedef struct packed {
        logic [15:0]       flags;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] buf_addr;
    } desc_t;

    typedef enum logic [1:0] {SRC_NONE, SRC_CB, SRC_DATA, SRC_PAD} src_e;

    typedef enum logic [2:0] {
        W_IDLE, W_DROP, W_FETCH, W_LOAD, W_FILL, W_BACK, W_HALT
    } wstate_e;

    function automatic logic [15:0] wb_flags(input logic [15:0] f, input logic first,
                                             input logic last, input logic lg, input logic sh);
        logic [15:0] r;
        r = f;
        r[F_EMPTY] = 1'b0;
        if (first) r[F_FIRST] = 1'b1;
        if (last) begin
            r[10:0]   = '0;
            r[F_LAST] = 1'b1;
            r[F_LG]   = lg;
            r[F_SH]   = sh;
        end
        return r;
    endfunction
endpackage

// File: rtl/rxr_admit.sv
module rxr_admit
    import rxr_pkg::*;
(
    input  logic             rx_enable,
    input  logic             graceful_stop,
    input  logic             reject_short,
    input  logic [LEN_W-1:0] in_len,
    input  logic [1:0]       parse_depth,
    input  logic [4:0]       cb_align,
    output logic             take,
    output logic [CB_W-1:0]  cb_size
);
    logic too_short;
    assign too_short = reject_short && (in_len < LEN_W'(SHORT_DROP));
    assign take      = rx_enable && !graceful_stop && !too_short;
    assign cb_size   = (parse_depth != 2'd0) ? CB_W'(CB_BASE) + CB_W'(cb_align) : '0;
endmodule

// File: rtl/rxr_source.sv
module rxr_source
    import rxr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CB_W-1:0]  cb_size,
    input  logic [LEN_W-1:0] data_len,
    input  logic             adv,
    output src_e             kind,
    output logic [REM_W-1:0] remaining
);
    localparam int PAD_W = $clog2(PAD_N + 1);

    logic [CB_W-1:0]  cb_left;
    logic [LEN_W-1:0] data_left;
    logic [PAD_W-1:0] pad_left;

    always_comb begin
        if (cb_left != '0)        kind = SRC_CB;
        else if (data_left != '0) kind = SRC_DATA;
        else if (pad_left != '0)  kind = SRC_PAD;
        else                      kind = SRC_NONE;
    end

    assign remaining = REM_W'(cb_left) + REM_W'(data_left) + REM_W'(pad_left);

    always_ff @(posedge clk) begin
        if (rst) begin
            cb_left   <= '0;
            data_left <= '0;
            pad_left  <= '0;
        end else if (load) begin
            cb_left   <= cb_size;
            data_left <= data_len;
            pad_left  <= PAD_W'(PAD_N);
        end else if (adv) begin
            case (kind)
                SRC_CB:   cb_left   <= cb_left - 1'b1;
                SRC_DATA: data_left <= data_left - 1'b1;
                SRC_PAD:  pad_left  <= pad_left - 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/rxr_walker.sv
module rxr_walker
    import rxr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              ptr_wr,
    input  logic [ADDR_W-1:0] ptr_wdata,
    output logic [ADDR_W-1:0] ring_ptr,
    input  logic [LEN_W-1:0]  max_buf_len,
    input  logic [LEN_W-1:0]  max_frame_len,
    input  logic              irq_frame_en,
    input  logic              irq_buf_en,
    input  logic              halt_bit,
    input  logic              take,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic [LEN_W-1:0]  in_len,
    input  src_e              kind,
    input  logic [REM_W-1:0]  remaining,
    output logic              src_load,
    output logic              src_adv,
    output logic              desc_rd,
    output logic              desc_wr,
    output logic [ADDR_W-1:0] desc_addr,
    input  desc_t             desc_rdata,
    output desc_t             desc_wdata,
    output logic              data_wr,
    output logic [ADDR_W-1:0] data_addr,
    output logic [7:0]        data_byte,
    output logic              set_halt,
    output logic              set_frame,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(STRIDE - 1);

    wstate_e           state;
    logic [ADDR_W-1:0] ptr, walk_start, wptr, cur_buf, next_ptr;
    logic [15:0]       cur_flags;
    logic [LEN_W-1:0]  cnt, drop_left;
    logic [REM_W-1:0]  tot;
    logic              first, emit, fill_end, last, lap, int_on;

    assign next_ptr = cur_flags[F_WRAP] ? (ring_base & ALIGN_MASK) : ptr + ADDR_W'(STRIDE);
    assign emit     = (state == W_FILL) && (kind != SRC_NONE) && ((kind != SRC_DATA) || in_valid);
    assign fill_end = emit && ((remaining == REM_W'(1)) || (cnt + 1'b1 == max_buf_len));
    assign last     = (remaining == '0);
    assign lap      = (next_ptr == walk_start);
    assign int_on   = cur_flags[F_INT];

    assign in_ready  = (state == W_DROP) || ((state == W_FILL) && (kind == SRC_DATA));
    assign src_load  = (state == W_IDLE) && in_valid && !halt_bit && take;
    assign src_adv   = emit;
    assign ring_ptr  = ptr;
    assign desc_rd   = (state == W_FETCH);
    assign desc_wr   = (state == W_BACK);
    assign desc_addr = ptr;
    assign data_wr   = emit;
    assign data_addr = wptr;
    assign data_byte = (kind == SRC_DATA) ? in_data : 8'h00;

    always_comb begin
        desc_wdata.flags    = wb_flags(cur_flags, first, last,
                                       tot >= REM_W'(max_frame_len), tot < REM_W'(SHORT_MARK));
        desc_wdata.len      = cnt;
        desc_wdata.buf_addr = cur_buf;
    end

    assign set_halt  = ((state == W_LOAD) && !desc_rdata.flags[F_EMPTY]) ||
                       ((state == W_BACK) && !last && lap);
    assign set_frame = (state == W_BACK) && last && int_on;
    assign irq       = (state == W_BACK) && int_on && (last ? irq_frame_en : irq_buf_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= W_IDLE;
            ptr        <= '0;
            walk_start <= '0;
            wptr       <= '0;
            cur_buf    <= '0;
            cur_flags  <= '0;
            cnt        <= '0;
            drop_left  <= '0;
            tot        <= '0;
            first      <= 1'b0;
        end else begin
            if (ptr_wr && (state == W_IDLE || state == W_HALT))
                ptr <= ptr_wdata & ALIGN_MASK;
            case (state)
                W_IDLE: if (in_valid && !halt_bit) begin
                    if (take) begin
                        first      <= 1'b1;
                        walk_start <= ptr;
                        tot        <= REM_W'(in_len) + REM_W'(PAD_N);
                        state      <= W_FETCH;
                    end else begin
                        drop_left <= in_len;
                        state     <= W_DROP;
                    end
                end
                W_DROP: if (in_valid) begin
                    drop_left <= drop_left - 1'b1;
                    if (drop_left == LEN_W'(1)) state <= W_IDLE;
                end
                W_FETCH: state <= W_LOAD;
                W_LOAD: begin
                    cur_flags <= desc_rdata.flags;
                    cur_buf   <= desc_rdata.buf_addr;
                    wptr      <= desc_rdata.buf_addr;
                    cnt       <= '0;
                    state     <= desc_rdata.flags[F_EMPTY] ? W_FILL : W_HALT;
                end
                W_FILL: if (emit) begin
                    cnt  <= cnt + 1'b1;
                    wptr <= wptr + 1'b1;
                    if (fill_end) state <= W_BACK;
                end
                W_BACK: begin
                    first <= 1'b0;
                    ptr   <= next_ptr;
                    if (last)     state <= W_IDLE;
                    else if (lap) state <= W_HALT;
                    else          state <= W_FETCH;
                end
                W_HALT: if (!halt_bit) begin
                    walk_start <= ptr;
                    state      <= W_FETCH;
                end
                default: state <= W_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_ring_filler.sv
module rx_ring_filler
    import rxr_pkg::*;
#(
    parameter int RING = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              ptr_wr,
    input  logic [ADDR_W-1:0] ptr_wdata,
    output logic [ADDR_W-1:0] ring_ptr,
    input  logic [LEN_W-1:0]  max_buf_len,
    input  logic [LEN_W-1:0]  max_frame_len,
    input  logic              rx_enable,
    input  logic              graceful_stop,
    input  logic              reject_short,
    input  logic [1:0]        parse_depth,
    input  logic [4:0]        cb_align,
    input  logic              irq_frame_en,
    input  logic              irq_buf_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic [LEN_W-1:0]  in_len,
    output logic              desc_rd,
    output logic              desc_wr,
    output logic [ADDR_W-1:0] desc_addr,
    input  logic [63:0]       desc_rdata,
    output logic [63:0]       desc_wdata,
    output logic              data_wr,
    output logic [ADDR_W-1:0] data_addr,
    output logic [7:0]        data_byte,
    output logic [31:0]       stat,
    input  logic [31:0]       stat_clr,
    output logic              rx_irq
);
    localparam int HALT_POS  = 23 - RING;
    localparam int FRAME_POS = 7 - RING;

    logic             take, src_load, src_adv, set_halt, set_frame;
    logic [CB_W-1:0]  cb_size;
    src_e             kind;
    logic [REM_W-1:0] remaining;
    desc_t            rd_d, wr_d;
    logic [31:0]      set_vec;

    assign rd_d       = desc_t'(desc_rdata);
    assign desc_wdata = wr_d;

    rxr_admit u_admit (
        .rx_enable(rx_enable), .graceful_stop(graceful_stop), .reject_short(reject_short),
        .in_len(in_len), .parse_depth(parse_depth), .cb_align(cb_align),
        .take(take), .cb_size(cb_size)
    );

    rxr_source u_src (
        .clk(clk), .rst(rst), .load(src_load), .cb_size(cb_size), .data_len(in_len),
        .adv(src_adv), .kind(kind), .remaining(remaining)
    );

    rxr_walker u_walk (
        .clk(clk), .rst(rst), .ring_base(ring_base), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
        .ring_ptr(ring_ptr), .max_buf_len(max_buf_len), .max_frame_len(max_frame_len),
        .irq_frame_en(irq_frame_en), .irq_buf_en(irq_buf_en), .halt_bit(stat[HALT_POS]),
        .take(take), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_len(in_len), .kind(kind), .remaining(remaining), .src_load(src_load),
        .src_adv(src_adv), .desc_rd(desc_rd), .desc_wr(desc_wr), .desc_addr(desc_addr),
        .desc_rdata(rd_d), .desc_wdata(wr_d), .data_wr(data_wr), .data_addr(data_addr),
        .data_byte(data_byte), .set_halt(set_halt), .set_frame(set_frame), .irq(rx_irq)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[HALT_POS]  = set_halt;
        set_vec[FRAME_POS] = set_frame;
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= (stat & ~stat_clr) | set_vec;
    end
endmodule

// File: rtl/rx_ring_filler_chk.sv
module rx_ring_filler_chk #(
    parameter int RING = 0
) (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic [31:0] stat,
    input logic        desc_wr,
    input logic [63:0] desc_wdata,
    input logic [15:0] max_buf_len,
    input logic        rx_irq
);
    localparam int HALT_POS = 23 - RING;

    a_r1_empty_cleared: assert property (@(posedge clk) disable iff (rst)
        desc_wr |-> !desc_wdata[63 - 0]);

    a_r2_len_capped: assert property (@(posedge clk) disable iff (rst)
        desc_wr |-> (desc_wdata[47:32] <= max_buf_len) && (desc_wdata[47:32] != 16'd0));

    a_r5_last_low_bits: assert property (@(posedge clk) disable iff (rst)
        (desc_wr && desc_wdata[48 + 11]) |-> ((desc_wdata[58:48] & ~11'h028) == 11'd0));

    a_r8_irq_on_writeback: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> (desc_wr && desc_wdata[48 + 12]));

    a_r10_stall_while_halted: assert property (@(posedge clk) disable iff (rst)
        stat[HALT_POS] |-> !in_ready);
endmodule

bind rx_ring_filler rx_ring_filler_chk #(.RING(RING)) u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .stat(stat), .desc_wr(desc_wr),
    .desc_wdata(desc_wdata), .max_buf_len(max_buf_len), .rx_irq(rx_irq)
);

// File: tb/rx_ring_filler_test.sv
module rx_ring_filler_test;
    localparam int RING = 2;
    localparam int ND = 8;
    localparam int HB = 23 - RING;
    localparam int FB = 7 - RING;

    logic clk = 1'b0, rst = 1'b1;
    logic [31:0] ring_base = 32'h0, ptr_wdata = 32'h0, ring_ptr, desc_addr, data_addr, stat;
    logic [31:0] stat_clr = 32'h0;
    logic ptr_wr = 1'b0, rx_enable = 1'b1, graceful_stop = 1'b0, reject_short = 1'b0;
    logic [15:0] max_buf_len = 16'd64, max_frame_len = 16'd1600, in_len = 16'd0;
    logic [1:0] parse_depth = 2'd0;
    logic [4:0] cb_align = 5'd0;
    logic irq_frame_en = 1'b1, irq_buf_en = 1'b1, in_valid = 1'b0, in_ready;
    logic [7:0] in_data = 8'h0, data_byte;
    logic desc_rd, desc_wr, data_wr, rx_irq;
    logic [63:0] desc_rdata = 64'h0, desc_wdata;

    rx_ring_filler #(.RING(RING)) uut (.*);

    always #5 clk = ~clk;

    logic [63:0] dmem [ND];
    logic [7:0]  bmem [4096];
    always @(posedge clk) begin
        if (desc_rd) desc_rdata <= dmem[desc_addr[5:3]];
        if (desc_wr) dmem[desc_addr[5:3]] <= desc_wdata;
        if (data_wr) bmem[data_addr[11:0]] <= data_byte;
    end

    int irq_cnt = 0;
    always @(posedge clk) if (!rst && rx_irq) irq_cnt <= irq_cnt + 1;

    int n_tests = 0, n_fail = 0;
    logic [7:0] frm [2048];
    int f_len, f_cb, m_pos, m_total, m_ptr, exp_irq;
    bit m_empty [ND];
    bit frame_first, drv_done;
    int r_n;
    int r_desc [32], r_len [32], r_pos [32];
    bit r_first [32], r_last [32];

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #1_500_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    function automatic logic [31:0] buf_of(input int i);
        return 32'h200 + 32'(i) * 32'h100;
    endfunction

    function automatic logic [15:0] arm_flags(input int i);
        return 16'h9000 | ((i == ND - 1) ? 16'h2000 : 16'h0);
    endfunction

    function automatic logic [7:0] byte_at(input int s);
        if (s < f_cb) return 8'h00;
        if (s < f_cb + f_len) return frm[s - f_cb];
        return 8'h00;
    endfunction

    task automatic arm(input int i);
        dmem[i] = {arm_flags(i), 16'h0, buf_of(i)};
        m_empty[i] = 1'b1;
        for (int k = 0; k < 256; k++) bmem[buf_of(i) + 32'(k)] = 8'hEE;
    endtask

    task automatic arm_all();
        for (int i = 0; i < ND; i++) arm(i);
    endtask

    task automatic clr_stat(input logic [31:0] m);
        @(negedge clk); stat_clr = m;
        @(negedge clk); stat_clr = 32'h0;
    endtask

    task automatic drive_frame();
        drv_done = 1'b0;
        for (int i = 0; i < f_len; i++) begin
            while ($urandom % 4 == 0) begin
                @(negedge clk); in_valid = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1; in_data = frm[i]; in_len = 16'(f_len);
            #4;
            while (!in_ready) begin
                @(posedge clk); #4;
            end
            @(posedge clk);
        end
        @(negedge clk); in_valid = 1'b0;
        drv_done = 1'b1;
    endtask

    task automatic model_walk(output bit halted);
        int start, n;
        start = m_ptr; r_n = 0; halted = 1'b0; exp_irq = 0;
        while (m_pos < m_total) begin
            if (!m_empty[m_ptr]) begin halted = 1'b1; break; end
            n = m_total - m_pos;
            if (n > int'(max_buf_len)) n = int'(max_buf_len);
            r_desc[r_n] = m_ptr; r_len[r_n] = n; r_pos[r_n] = m_pos;
            r_first[r_n] = frame_first; frame_first = 1'b0;
            m_pos += n;
            r_last[r_n] = (m_pos == m_total);
            exp_irq += r_last[r_n] ? int'(irq_frame_en) : int'(irq_buf_en);
            r_n++;
            m_empty[m_ptr] = 1'b0;
            m_ptr = (m_ptr == ND - 1) ? 0 : m_ptr + 1;
            if (m_pos < m_total && m_ptr == start) begin halted = 1'b1; break; end
        end
    endtask

    task automatic verify(input bit halted, input string tag);
        logic [15:0] ef;
        bit ok, any_last;
        int i, tot;
        any_last = 1'b0;
        tot = f_len + 4;
        for (int r = 0; r < r_n; r++) begin
            i = r_desc[r];
            ef = arm_flags(i) & 16'h7FFF;
            if (r_first[r]) ef[14] = 1'b1;
            if (r_last[r]) begin
                any_last = 1'b1;
                ef[11] = 1'b1;
                ef[5] = (tot >= int'(max_frame_len));
                ef[3] = (tot < 64);
            end
            chk({dmem[i][63:48], dmem[i][47:32]} == {ef, 16'(r_len[r])}, "R1 R5 R6",
                {tag, " descriptor flags/len"}, {dmem[i][63:48], dmem[i][47:32]}, {ef, 16'(r_len[r])});
            ok = 1'b1;
            for (int k = 0; k < r_len[r]; k++)
                if (bmem[buf_of(i) + 32'(k)] !== byte_at(r_pos[r] + k)) ok = 1'b0;
            if (r_len[r] < 256 && bmem[buf_of(i) + 32'(r_len[r])] !== 8'hEE) ok = 1'b0;
            chk(ok, "R2 R3 R4", {tag, " buffer bytes"}, i, r_pos[r]);
        end
        chk(ring_ptr == 32'(m_ptr * 8), halted ? "R9" : "R11", {tag, " pointer"}, ring_ptr, m_ptr * 8);
        chk(stat[HB] == halted, "R9", {tag, " halt bit"}, stat[HB], halted);
        chk(irq_cnt == exp_irq, "R8", {tag, " irq pulses"}, irq_cnt, exp_irq);
        chk(stat[FB] == any_last, "R8", {tag, " frame status bit"}, stat[FB], any_last);
    endtask

    task automatic run_frame(input int len, input int cb, input string tag);
        bit h;
        f_len = len; f_cb = cb;
        for (int k = 0; k < len; k++) frm[k] = 8'($urandom);
        m_total = cb + len + 4; m_pos = 0; frame_first = 1'b1;
        clr_stat(32'(1) << FB);
        irq_cnt = 0;
        fork drive_frame(); join_none
        do begin
            model_walk(h);
            if (h) begin
                for (int k = 0; k < 3000; k++) begin
                    @(negedge clk);
                    if (stat[HB]) break;
                end
                repeat (3) @(negedge clk);
                chk(!in_ready, "R10", {tag, " stalled while halted"}, in_ready, 0);
                verify(1'b1, tag);
                arm_all();
                irq_cnt = 0;
                clr_stat((32'(1) << HB) | (32'(1) << FB));
            end else begin
                for (int k = 0; k < 20000; k++) begin
                    @(negedge clk);
                    if (drv_done) break;
                end
                repeat (40) @(negedge clk);
                verify(1'b0, tag);
            end
        end while (h);
    endtask

    task automatic run_drop(input int len, input string why);
        logic [63:0] snap [ND];
        logic [31:0] p0;
        for (int i = 0; i < ND; i++) snap[i] = dmem[i];
        p0 = ring_ptr;
        f_len = len;
        for (int k = 0; k < len; k++) frm[k] = 8'($urandom);
        irq_cnt = 0;
        fork drive_frame(); join_none
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (drv_done) break;
        end
        repeat (10) @(negedge clk);
        chk(drv_done, "R7", {why, " bytes consumed"}, drv_done, 1);
        begin
            bit same;
            same = (ring_ptr == p0) && (irq_cnt == 0);
            for (int i = 0; i < ND; i++) if (dmem[i] !== snap[i]) same = 1'b0;
            chk(same, "R7", {why, " no memory change"}, ring_ptr, p0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        arm_all();
        repeat (3) @(negedge clk);
        chk(!in_ready && stat == 0 && !desc_rd && !desc_wr && !data_wr, "R12", "reset state",
            {in_ready, stat[7:0]}, 0);
        rst = 1'b0;
        @(negedge clk);
        m_ptr = 0;

        max_buf_len = 16'd64;
        run_frame(100, 0, "basic two buffers");
        arm_all();
        parse_depth = 2'd1; cb_align = 5'd3;
        run_frame(60, 11, "control block R4");
        parse_depth = 2'd0; cb_align = 5'd0;
        arm_all();
        run_frame(62, 0, "pad spill R3");
        arm_all();
        run_frame(20, 0, "short mark R6");
        arm_all();
        max_frame_len = 16'd70;
        run_frame(66, 0, "length violation R6");
        arm_all();
        run_frame(65, 0, "below violation R6");
        max_frame_len = 16'd1600;

        arm_all();
        reject_short = 1'b1;
        run_drop(59, "short drop");
        run_frame(60, 0, "short boundary accepted R7");
        reject_short = 1'b0;
        arm_all();
        rx_enable = 1'b0;
        run_drop(80, "rx disabled");
        rx_enable = 1'b1;
        graceful_stop = 1'b1;
        run_drop(80, "graceful stop");
        graceful_stop = 1'b0;

        arm_all();
        dmem[(m_ptr + 2) % ND][63] = 1'b0;
        m_empty[(m_ptr + 2) % ND] = 1'b0;
        irq_buf_en = 1'b0;
        run_frame(200, 0, "non-empty halt R9");
        irq_buf_en = 1'b1;
        arm_all();
        max_buf_len = 16'd48;
        irq_frame_en = 1'b0;
        run_frame(400, 0, "lap halt R9");
        irq_frame_en = 1'b1;

        for (int t = 0; t < 25; t++) begin
            int cb, lmax, len;
            arm_all();
            max_buf_len = 16'(48 + $urandom % 81);
            parse_depth = 2'($urandom % 2);
            cb_align = 5'($urandom);
            cb = (parse_depth != 0) ? 8 + int'(cb_align) : 0;
            irq_frame_en = 1'($urandom); irq_buf_en = 1'($urandom);
            lmax = 8 * int'(max_buf_len) - 4 - cb;
            if (lmax > 600) lmax = 600;
            len = 1 + int'($urandom % lmax);
            run_frame(len, cb, "random R2");
        end
        finish_up();
    end
endmodule